// File: doc/BRIEF.md
# Gated Timer/Counter Unit

A single 16-bit counting channel with two sources. In interval-timer mode it advances once per machine cycle, where a machine cycle is twelve clocks of the input clock, generated by a free-running divider. In event-counter mode it advances once for each falling edge seen on an external event pin. That pin is looked at only once per machine cycle, so a falling edge means a high reading in one machine cycle followed by a low reading in the next.

A run bit enables counting. When the gate-enable bit is also set, counting additionally needs an external gate pin to be high. This lets the channel measure the length of a high pulse on the gate pin, either in machine cycles or in counted events. Both external pins pass through a two-flop synchroniser before they are used. When the count wraps from all ones to zero, a sticky overflow flag is set. The flag stays set until it is cleared with a dedicated clear input.

Top module: `gated_tmr_cnt`

## Requirements
- R1: Asserting the active-low reset clears the count to 0, the overflow flag to 0 and the event-pin history to low, so a low event pin seen in the first machine cycle after reset is not counted as an edge.
- R2: With the select input at 0 (timer), run at 1 and gating off, the count advances by exactly 1 once every 12 clocks and holds in between.
- R3: With the select input at 1 (counter), the count advances by 1 only for machine cycles where the synchronised event pin was sampled 1 in the previous machine cycle and 0 in this one. Any other pair of samples leaves the count unchanged.
- R4: The event pin is sampled only once per machine cycle, so a low pulse that starts and ends between two sampling points is not counted.
- R5: The count increases at the clock edge that ends the machine cycle in which the low sample is taken. After the pin falls, the count is still unchanged 11 clocks later and has increased after 12 clocks.
- R6: With run at 1 and gate-enable at 1, the count advances only in machine cycles where the synchronised gate pin is high. A high pulse of N machine cycles in timer mode adds exactly N.
- R7: With gate-enable at 0 the gate pin has no effect. With run at 0 the count never changes.
- R8: Counting past 0xFFFF gives 0x0000 and sets the overflow flag, which stays set while counting continues.
- R9: A one-clock pulse on the overflow-clear input drops the flag to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Run enable |
| gateEn | input | 1 | Gate enable: the gate pin must also be high to count |
| evtSel | input | 1 | Source select: 1 counts event-pin falling edges, 0 counts machine cycles |
| ovfClr | input | 1 | Clears the overflow flag |
| evtPin | input | 1 | External event pin (asynchronous) |
| gatePin | input | 1 | External gate pin (asynchronous) |
| count | output | 16 | Current count |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that the control bits run, gate-enable and source select are steady around the machine-cycle strobe edge. They also assume that the clear input is never raised in the same clock as a wrap, because that case is not specified. The bench changes every control bit and pin only on the falling clock edge right after a strobe edge. This gives each pin change ten or more clocks to pass through the synchroniser before the next sample point. The clear pulse is placed many machine cycles away from the wrap.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  // Strobes handed from the control block to the datapath
  typedef struct packed {
    logic incr;     // advance the count by one this clock
    logic flagClr;  // request to drop the overflow flag
  } gtc_stb_t;
endpackage

// File: rtl/gtc_prescale.sv
module gtc_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rstN,
  output logic mcStrobe
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign mcStrobe = (phase == LAST);
endmodule

// File: rtl/gtc_sync.sv
module gtc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= '0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/gtc_ctrl.sv
module gtc_ctrl
  import gtc_pkg::*;
#(
  parameter int DIV         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     runEn,
  input  logic     gateEn,
  input  logic     evtSel,
  input  logic     ovfClr,
  input  logic     evtPin,
  input  logic     gatePin,
  output gtc_stb_t stb,
  output logic     mcStrobe,
  output logic     gateLvl
);
  localparam int PINS = 2;

  logic [PINS-1:0] pinSync;
  logic            evtLvl;
  logic            evtHist;
  logic            fallSeen;
  logic            countOk;
  logic            srcTick;

  gtc_prescale #(.DIV(DIV)) uPresc (
    .clk     (clk),
    .rstN    (rstN),
    .mcStrobe(mcStrobe)
  );

  gtc_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({gatePin, evtPin}),
    .syncOut(pinSync)
  );

  assign evtLvl  = pinSync[0];
  assign gateLvl = pinSync[1];

  // Level of the event pin taken at the previous sample point
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         evtHist <= 1'b0;
    else if (mcStrobe) evtHist <= evtLvl;
  end

  assign fallSeen = evtHist & ~evtLvl;
  assign countOk  = runEn & (~gateEn | gateLvl);
  assign srcTick  = evtSel ? fallSeen : 1'b1;

  always_comb begin
    stb.incr    = mcStrobe & countOk & srcTick;
    stb.flagClr = ovfClr;
  end
endmodule

// File: rtl/gtc_dp.sv
module gtc_dp
  import gtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  gtc_stb_t         stb,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic wrapNow;

  assign wrapNow = stb.incr && (count == MAXV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         count <= '0;
    else if (stb.incr) count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ovfFlag <= 1'b0;
    else if (wrapNow)     ovfFlag <= 1'b1;
    else if (stb.flagClr) ovfFlag <= 1'b0;
  end
endmodule

// File: rtl/gated_tmr_cnt.sv
module gated_tmr_cnt
  import gtc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             gateEn,
  input  logic             evtSel,
  input  logic             ovfClr,
  input  logic             evtPin,
  input  logic             gatePin,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag
);
  gtc_stb_t stb;
  logic     mcStrobe;
  logic     gateLvl;

  gtc_ctrl #(.DIV(DIV), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .runEn   (runEn),
    .gateEn  (gateEn),
    .evtSel  (evtSel),
    .ovfClr  (ovfClr),
    .evtPin  (evtPin),
    .gatePin (gatePin),
    .stb     (stb),
    .mcStrobe(mcStrobe),
    .gateLvl (gateLvl)
  );

  gtc_dp #(.CNT_W(CNT_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .count  (count),
    .ovfFlag(ovfFlag)
  );
endmodule

// File: rtl/gated_tmr_cnt_chk.sv
module gated_tmr_cnt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             runEn,
  input logic             gateEn,
  input logic             ovfClr,
  input logic             mcStrobe,
  input logic             gateLvl,
  input logic [CNT_W-1:0] count,
  input logic             ovfFlag
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  always @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_clear: assert (count == '0 && !ovfFlag)
        else $error("count or flag not cleared in reset");
    end
  end

  // R2: updates happen only on the machine-cycle strobe
  a_r2_change_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |-> $past(mcStrobe));

  // R8: the count only ever moves by one, wrapping at the top
  a_r8_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |-> (count == $past(count) + CNT_W'(1)));

  // R7: no run, no movement
  a_r7_run_low_holds: assert property (@(posedge clk) disable iff (!rstN)
    (mcStrobe && !runEn) |=> $stable(count));

  // R6: gated and gate pin low, no movement
  a_r6_gate_low_holds: assert property (@(posedge clk) disable iff (!rstN)
    (mcStrobe && gateEn && !gateLvl) |=> $stable(count));

  // R8: a wrap leaves the flag set
  a_r8_flag_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ($past(count) == MAXV && count == '0) |-> ovfFlag);

  // R9: a clear away from a wrap drops the flag
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    (ovfClr && count != MAXV) |=> !ovfFlag);
endmodule

bind gated_tmr_cnt gated_tmr_cnt_chk #(.CNT_W(CNT_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .runEn   (runEn),
  .gateEn  (gateEn),
  .ovfClr  (ovfClr),
  .mcStrobe(mcStrobe),
  .gateLvl (gateLvl),
  .count   (count),
  .ovfFlag (ovfFlag)
);

// File: tb/tb_gated_tmr_cnt.sv
`timescale 1ns/1ps
module tb_gated_tmr_cnt;
  localparam int MC      = 12;
  localparam int FAST_MC = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, runEn, gateEn, evtSel, ovfClr, evtPin, gatePin;
  logic [15:0] count;
  logic ovfFlag;

  logic fRun, fClr;
  logic [15:0] fCount;
  logic fFlag;

  int vectors = 0;
  int errors  = 0;
  bit resetsDone = 1'b0;
  bit ovfDone = 1'b0;
  bit finished = 1'b0;
  int expCnt;

  gated_tmr_cnt dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .gateEn(gateEn), .evtSel(evtSel),
    .ovfClr(ovfClr), .evtPin(evtPin), .gatePin(gatePin),
    .count(count), .ovfFlag(ovfFlag)
  );

  // Short machine cycle so that a full wrap fits in the run
  gated_tmr_cnt #(.DIV(FAST_MC)) ovfDut (
    .clk(clk), .rstN(rstN), .runEn(fRun), .gateEn(1'b0), .evtSel(1'b0),
    .ovfClr(fClr), .evtPin(1'b0), .gatePin(1'b0),
    .count(fCount), .ovfFlag(fFlag)
  );

  task automatic chk(input string req, input int act, input int expv);
    vectors++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic stepMc();
    repeat (MC) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  // Overflow thread on the fast instance
  initial begin
    fRun = 1'b0; fClr = 1'b0;
    wait (resetsDone);
    fRun = 1'b1;
    repeat (FAST_MC * 65535) @(posedge clk);
    @(negedge clk);
    chk("R8 count at top", fCount, 65535);
    chk("R8 flag before wrap", fFlag, 0);
    repeat (FAST_MC) @(posedge clk);
    @(negedge clk);
    chk("R8 count wraps", fCount, 0);
    chk("R8 flag set", fFlag, 1);
    repeat (FAST_MC * 10) @(posedge clk);
    @(negedge clk);
    chk("R8 flag sticky", fFlag, 1);
    chk("R8 count after wrap", fCount, 10);
    fClr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fClr = 1'b0;
    chk("R9 flag cleared", fFlag, 0);
    ovfDone = 1'b1;
  end

  initial begin
    rstN = 1'b0; runEn = 1'b0; gateEn = 1'b0; evtSel = 1'b0;
    ovfClr = 1'b0; evtPin = 1'b1; gatePin = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset count", count, 0);
    chk("R1 reset flag", ovfFlag, 0);

    // Build a high history, then reset with the pin low
    evtSel = 1'b1; runEn = 1'b1;
    stepMc(); stepMc();
    chk("R3 steady high no count", count, 0);
    rstN = 1'b0; evtPin = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    resetsDone = 1'b1;
    stepMc();
    chk("R1 history cleared", count, 0);
    expCnt = 0;

    // R2: timer cadence
    evtSel = 1'b0; gateEn = 1'b0; runEn = 1'b1;
    repeat (MC - 1) @(posedge clk);
    @(negedge clk);
    chk("R2 no step before 12 clocks", count, expCnt);
    @(posedge clk);
    @(negedge clk);
    expCnt++;
    chk("R2 step at 12 clocks", count, expCnt);
    for (int k = 0; k < 5; k++) begin
      stepMc();
      expCnt++;
      chk("R2 one per machine cycle", count, expCnt);
    end

    // R3 R6 R7: sweep of every control and pin combination
    for (int v = 0; v < 64; v++) begin
      bit r, g, gp, s, pv, cu;
      {r, g, gp, s, pv, cu} = 6'(v);
      runEn = 1'b0; evtPin = pv;
      stepMc();
      runEn = r; gateEn = g; gatePin = gp; evtSel = s; evtPin = cu;
      stepMc();
      if (r && (!g || gp) && (!s || (pv && !cu))) expCnt++;
      chk($sformatf("R3 R6 R7 sweep %0d", v), count, expCnt);
    end

    // R4: a short low pulse between samples is missed
    runEn = 1'b1; gateEn = 1'b0; evtSel = 1'b1; evtPin = 1'b1;
    stepMc();
    repeat (3) @(posedge clk);
    @(negedge clk); evtPin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); evtPin = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R4 glitch ignored", count, expCnt);

    // R5: when a real edge shows up
    evtPin = 1'b0;
    repeat (MC - 1) @(posedge clk);
    @(negedge clk);
    chk("R5 not yet visible", count, expCnt);
    @(posedge clk);
    @(negedge clk);
    expCnt++;
    chk("R5 visible after sample", count, expCnt);
    stepMc();
    chk("R3 held low no count", count, expCnt);

    // R6: pulse width in machine cycles
    evtSel = 1'b0; gateEn = 1'b1; gatePin = 1'b0;
    repeat (3) stepMc();
    chk("R6 gate low holds", count, expCnt);
    gatePin = 1'b1;
    repeat (7) stepMc();
    expCnt += 7;
    chk("R6 width of 7", count, expCnt);
    gatePin = 1'b0;
    repeat (2) stepMc();
    chk("R6 gate closed", count, expCnt);

    // R6: gated edge counting
    evtSel = 1'b1; gatePin = 1'b1;
    for (int k = 0; k < 4; k++) begin
      evtPin = (k % 2 == 0);
      stepMc();
    end
    expCnt += 2;
    chk("R6 gated edges", count, expCnt);
    gatePin = 1'b0;
    evtPin = 1'b1; stepMc();
    evtPin = 1'b0; stepMc();
    chk("R6 gated off edges", count, expCnt);

    wait (ovfDone);
    summary();
  end
endmodule